// File: doc/BRIEF.md
# Clock Generator Mode Controller

This block is the control core of a clock source with two complementary output pairs. It decides, once per system clock cycle, which of four operating states the source is in: powered down, outputs stopped, normal, or test. It picks what each output pair carries: the phase-aligned clock, the raw multiplied clock, the reference clock, or nothing. It also decides whether each pair is driven, pulled low or left high-impedance. A high-impedance pin is modelled as a value plus an output enable.

The mode-select code is captured only while the source is powered down, and it is ignored at all other times. The multiplier code sets the feedback/prescaler pair of the frequency synthesiser. Each kind of state change loads its own settling latency into a counter, and a settled flag stays low until that latency has run out. A legal change of the multiplier code during normal operation restarts the settling interval. Every latency is a parameter counted in system clock cycles.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: The state is updated on each rising edge of `clk` from the inputs sampled at that edge. The priority order is:
  - power-down when `pwr_dn_n` is 0;
  - otherwise test when the captured mode code is not 000;
  - otherwise stopped when `stop_n` is 0;
  - otherwise normal.
  The one-hot `state_oh` encodes the state as bit0 power-down, bit1 stopped, bit2 normal and bit3 test.
- R2: In power-down, every output pair has `clk_oe` at 1 and both `clk_p` and `clk_n` at 0.
- R3: In the stopped state, every `clk_oe` bit is 0 and `clk_p`/`clk_n` read 0.
- R4: `mode_sel` is captured on every edge at which `pwr_dn_n` is 0. At all other edges it is ignored. Bit i of `mode_sel` is select line Si.
- R5: In the normal state, every pair is enabled, `clk_p` equals `clk_aligned`, and `clk_n` is its complement.
- R6: In the test state, the captured code selects what the pairs carry. `mode_sel`=3'b001 (bypass) carries `clk_pll`. 3'b011 carries `clk_ref`. 3'b010 and 3'b110 (output test) and the codes 3'b100, 3'b101 and 3'b111 disable every pair (`clk_oe`=0, values 0).
- R7: In the test state, `stop_n` has no effect.
- R8: `mult_sel` (bit i is multiplier line i) gives the synthesiser ratio A/B as follows: 000→4/1, 100→9/2, 010→6/1, 001→8/3, 101→16/3, 011→8/1. The ratio appears on `ratio_a`/`ratio_b` one cycle after the code changes.
- R9: The codes 3'b110 and 3'b111 leave the ratio unchanged and set `mult_err`. `mult_err` stays set until reset.
- R10: On any exit from power-down, `settled` is 0 for exactly `T_PUP` cycles counted from the edge at which the state changed.
- R11: On entry into power-down, `settled` is 0 for exactly `T_PDN` cycles.
- R12: Stopped to normal holds `settled` low for `T_ON`+`T_SETL` cycles. Normal to stopped holds it low for `T_OFF` cycles.
- R13: A change to a legal multiplier code while the state stays normal restarts a `T_MULT`-cycle settling interval. Multiplier changes in any other state leave the timer alone.
- R14: While `rst` is high, the block sits in power-down with `settled`=1, ratio 4/1, `mult_err`=0 and a captured mode of 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn_n | input | 1 | Power-down request, active low |
| stop_n | input | 1 | Output stop request, active low |
| mode_sel | input | 3 | Mode-select code, captured in power-down |
| mult_sel | input | 3 | Multiplier code |
| clk_aligned | input | 1 | Phase-aligned clock candidate |
| clk_pll | input | 1 | Raw multiplied clock candidate |
| clk_ref | input | 1 | Reference clock candidate |
| clk_p | output | NUM_OUT | True output of each pair |
| clk_n | output | NUM_OUT | Complement output of each pair |
| clk_oe | output | NUM_OUT | Drive enable of each pair (0 = high-impedance) |
| state_oh | output | 4 | One-hot state |
| settled | output | 1 | Current state latency has elapsed |
| ratio_a | output | 5 | Feedback divider A |
| ratio_b | output | 2 | Prescaler divider B |
| mult_err | output | 1 | Sticky illegal multiplier code flag |

## Verification
Several properties are checked on every cycle:
- the one-hot state;
- the pin conditions tied to each state: grounded pairs in power-down, disabled pairs when stopped, complementary enabled pairs in normal;
- the frozen mode capture outside power-down;
- the held ratio on an illegal code;
- the sticky error flag;
- a drop of `settled` after each timer load.

The exact length of each settling window, the source each test code picks, and that stop has no effect in test cannot be seen by a single-cycle property. These are shown only by the bench. Its scenario model compares every state, ratio, settled and pin value cycle by cycle over directed sequences and a long random run.

// File: rtl/clkgen_mode_pkg.sv
package clkgen_mode_pkg;

  localparam int unsigned RATIO_AW = 5;
  localparam int unsigned RATIO_BW = 2;

  typedef enum logic [1:0] {
    ST_PDN  = 2'd0,
    ST_STOP = 2'd1,
    ST_NORM = 2'd2,
    ST_TEST = 2'd3
  } cg_state_e;

  typedef enum logic [1:0] {
    SRC_ALIGN = 2'd0,
    SRC_PLL   = 2'd1,
    SRC_REF   = 2'd2
  } cg_src_e;

  typedef struct packed {
    logic    oe;
    logic    low;
    cg_src_e src;
  } drv_ctl_t;

  typedef struct packed {
    logic                ok;
    logic [RATIO_AW-1:0] a;
    logic [RATIO_BW-1:0] b;
  } ratio_t;

  localparam logic [2:0] MODE_NORMAL = 3'b000;
  localparam logic [2:0] MODE_BYPASS = 3'b001;
  localparam logic [2:0] MODE_REFOUT = 3'b011;

  function automatic int unsigned max2(int unsigned x, int unsigned y);
    return (x > y) ? x : y;
  endfunction

  // m[0] is multiplier line 0
  function automatic ratio_t decode_ratio(logic [2:0] m);
    ratio_t r;
    r.ok = 1'b1;
    r.a  = '0;
    r.b  = '0;
    case (m)
      3'b000: begin r.a = 5'd4;  r.b = 2'd1; end
      3'b100: begin r.a = 5'd9;  r.b = 2'd2; end
      3'b010: begin r.a = 5'd6;  r.b = 2'd1; end
      3'b001: begin r.a = 5'd8;  r.b = 2'd3; end
      3'b101: begin r.a = 5'd16; r.b = 2'd3; end
      3'b011: begin r.a = 5'd8;  r.b = 2'd1; end
      default: r.ok = 1'b0;
    endcase
    return r;
  endfunction

  function automatic drv_ctl_t drive_for(cg_state_e st, logic [2:0] mode);
    drv_ctl_t c;
    c.oe  = 1'b0;
    c.low = 1'b0;
    c.src = SRC_ALIGN;
    case (st)
      ST_PDN:  begin c.oe = 1'b1; c.low = 1'b1; end
      ST_NORM: begin c.oe = 1'b1; c.src = SRC_ALIGN; end
      ST_TEST: begin
        if (mode == MODE_BYPASS) begin
          c.oe = 1'b1; c.src = SRC_PLL;
        end else if (mode == MODE_REFOUT) begin
          c.oe = 1'b1; c.src = SRC_REF;
        end
      end
      default: c.oe = 1'b0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/clkgen_state_fsm.sv
module clkgen_state_fsm
  import clkgen_mode_pkg::*;
#(
  parameter int unsigned CW     = 4,
  parameter int unsigned T_PUP  = 8,
  parameter int unsigned T_PDN  = 4,
  parameter int unsigned T_OFF  = 1,
  parameter int unsigned T_ON   = 1,
  parameter int unsigned T_SETL = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_dn_n,
  input  logic          stop_n,
  input  logic [2:0]    mode_sel,
  output cg_state_e     state_q,
  output cg_state_e     state_d,
  output logic [2:0]    mode_q,
  output logic          trans,
  output logic [CW-1:0] trans_lat
);

  always_comb begin
    if (!pwr_dn_n)                 state_d = ST_PDN;
    else if (mode_q != MODE_NORMAL) state_d = ST_TEST;
    else if (!stop_n)              state_d = ST_STOP;
    else                           state_d = ST_NORM;
  end

  assign trans = (state_d != state_q);

  always_comb begin
    if (state_d == ST_PDN)
      trans_lat = CW'(T_PDN);
    else if (state_q == ST_PDN)
      trans_lat = CW'(T_PUP);
    else if (state_q == ST_NORM && state_d == ST_STOP)
      trans_lat = CW'(T_OFF);
    else if (state_q == ST_STOP && state_d == ST_NORM)
      trans_lat = CW'(T_ON + T_SETL);
    else
      trans_lat = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_PDN;
      mode_q  <= MODE_NORMAL;
    end else begin
      state_q <= state_d;
      if (!pwr_dn_n) mode_q <= mode_sel;
    end
  end

  // R4: captured mode frozen while powered up
  p_mode_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (pwr_dn_n && state_q != ST_PDN) |=> $stable(mode_q));

endmodule

// File: rtl/clkgen_ratio_sel.sv
module clkgen_ratio_sel
  import clkgen_mode_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          mult_sel,
  output logic [RATIO_AW-1:0] ratio_a,
  output logic [RATIO_BW-1:0] ratio_b,
  output logic                mult_err,
  output logic                good_change
);

  logic [2:0] mult_last;
  ratio_t     dec;
  logic       changed;

  assign dec         = decode_ratio(mult_sel);
  assign changed     = (mult_sel != mult_last);
  assign good_change = changed && dec.ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      mult_last <= 3'b000;
      ratio_a   <= RATIO_AW'(4);
      ratio_b   <= RATIO_BW'(1);
      mult_err  <= 1'b0;
    end else begin
      mult_last <= mult_sel;
      if (changed) begin
        if (dec.ok) begin
          ratio_a <= dec.a;
          ratio_b <= dec.b;
        end else begin
          mult_err <= 1'b1;
        end
      end
    end
  end

  // R9: illegal code keeps the ratio and the flag never clears
  p_hold_ratio_r9: assert property (@(posedge clk) disable iff (rst)
    (!dec.ok) |=> ($stable(ratio_a) && $stable(ratio_b)));
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    mult_err |=> mult_err);

endmodule

// File: rtl/clkgen_settle_timer.sv
module clkgen_settle_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] load,
  output logic          settled
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (start)         cnt_q <= load;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign settled = (cnt_q == '0);

  // R10/R11/R12/R13: a nonzero load always drops settled
  p_load_drops_r10: assert property (@(posedge clk) disable iff (rst)
    (start && load != '0) |=> !settled);

endmodule

// File: rtl/clkgen_out_drive.sv
module clkgen_out_drive
  import clkgen_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  drv_ctl_t ctl_d,
  input  logic     clk_aligned,
  input  logic     clk_pll,
  input  logic     clk_ref,
  output logic     out_p,
  output logic     out_n,
  output logic     out_oe
);

  drv_ctl_t ctl_q;
  logic     src_lvl;
  logic     live;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q.oe  <= 1'b1;
      ctl_q.low <= 1'b1;
      ctl_q.src <= SRC_ALIGN;
    end else begin
      ctl_q <= ctl_d;
    end
  end

  always_comb begin
    case (ctl_q.src)
      SRC_PLL: src_lvl = clk_pll;
      SRC_REF: src_lvl = clk_ref;
      default: src_lvl = clk_aligned;
    endcase
  end

  assign live   = ctl_q.oe && !ctl_q.low;
  assign out_p  = live && src_lvl;
  assign out_n  = live && !src_lvl;
  assign out_oe = ctl_q.oe;

endmodule

// File: rtl/clkgen_mode_ctrl.sv
module clkgen_mode_ctrl
  import clkgen_mode_pkg::*;
#(
  parameter int unsigned NUM_OUT = 2,
  parameter int unsigned T_PUP   = 300000,
  parameter int unsigned T_PDN   = 100000,
  parameter int unsigned T_OFF   = 1,
  parameter int unsigned T_ON    = 1,
  parameter int unsigned T_SETL  = 20,
  parameter int unsigned T_MULT  = 100000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwr_dn_n,
  input  logic               stop_n,
  input  logic [2:0]         mode_sel,
  input  logic [2:0]         mult_sel,
  input  logic               clk_aligned,
  input  logic               clk_pll,
  input  logic               clk_ref,
  output logic [NUM_OUT-1:0] clk_p,
  output logic [NUM_OUT-1:0] clk_n,
  output logic [NUM_OUT-1:0] clk_oe,
  output logic [3:0]         state_oh,
  output logic               settled,
  output logic [4:0]         ratio_a,
  output logic [1:0]         ratio_b,
  output logic               mult_err
);

  localparam int unsigned MAX_LAT = max2(max2(max2(T_PUP, T_PDN), max2(T_OFF, T_ON + T_SETL)), T_MULT);
  localparam int unsigned CW      = $clog2(MAX_LAT + 2);

  cg_state_e     state_q, state_d;
  logic [2:0]    mode_q;
  logic          trans;
  logic [CW-1:0] trans_lat;
  logic          good_change;
  logic          tmr_start;
  logic [CW-1:0] tmr_load;
  drv_ctl_t      ctl_d;

  clkgen_state_fsm #(
    .CW(CW), .T_PUP(T_PUP), .T_PDN(T_PDN), .T_OFF(T_OFF), .T_ON(T_ON), .T_SETL(T_SETL)
  ) u_fsm (
    .clk(clk), .rst(rst), .pwr_dn_n(pwr_dn_n), .stop_n(stop_n), .mode_sel(mode_sel),
    .state_q(state_q), .state_d(state_d), .mode_q(mode_q),
    .trans(trans), .trans_lat(trans_lat)
  );

  clkgen_ratio_sel u_ratio (
    .clk(clk), .rst(rst), .mult_sel(mult_sel),
    .ratio_a(ratio_a), .ratio_b(ratio_b), .mult_err(mult_err), .good_change(good_change)
  );

  // state change wins over a hot multiplier change
  assign tmr_start = trans || (good_change && state_q == ST_NORM && state_d == ST_NORM);
  assign tmr_load  = trans ? trans_lat : CW'(T_MULT);

  clkgen_settle_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .start(tmr_start), .load(tmr_load), .settled(settled)
  );

  assign ctl_d    = drive_for(state_d, mode_q);
  assign state_oh = 4'b0001 << state_q;

  for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_pair
    clkgen_out_drive u_drv (
      .clk(clk), .rst(rst), .ctl_d(ctl_d),
      .clk_aligned(clk_aligned), .clk_pll(clk_pll), .clk_ref(clk_ref),
      .out_p(clk_p[gi]), .out_n(clk_n[gi]), .out_oe(clk_oe[gi])
    );
  end

  p_state_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(state_oh) == 1);
  p_pdn_ground_r2: assert property (@(posedge clk) disable iff (rst)
    state_oh[0] |-> (clk_oe == {NUM_OUT{1'b1}} && clk_p == '0 && clk_n == '0));
  p_stop_hiz_r3: assert property (@(posedge clk) disable iff (rst)
    state_oh[1] |-> (clk_oe == '0));
  p_norm_compl_r5: assert property (@(posedge clk) disable iff (rst)
    state_oh[2] |-> (clk_oe == {NUM_OUT{1'b1}} && clk_n == ~clk_p));

endmodule

// File: tb/test_clkgen_mode_ctrl.sv
module test_clkgen_mode_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NOUT   = 2;
  localparam int L_PUP  = 12;
  localparam int L_PDN  = 5;
  localparam int L_OFF  = 2;
  localparam int L_ON   = 3;
  localparam int L_SETL = 6;
  localparam int L_MULT = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_dn_n = 1'b0, stop_n = 1'b1;
  logic [2:0] mode_sel = 3'b000, mult_sel = 3'b000;
  logic clk_aligned = 1'b0, clk_pll = 1'b0, clk_ref = 1'b0;
  logic [NOUT-1:0] clk_p, clk_n, clk_oe;
  logic [3:0] state_oh;
  logic settled, mult_err;
  logic [4:0] ratio_a;
  logic [1:0] ratio_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model
  int exp_state = 0;
  logic [2:0] exp_mode = 3'b000;
  logic [2:0] last_mult = 3'b000;
  int exp_cnt = 0;
  int exp_a = 4;
  int exp_b = 1;
  bit exp_err = 1'b0;
  string lat_tag = "R14";

  always #(CLK_PERIOD/2) clk = ~clk;

  clkgen_mode_ctrl #(
    .NUM_OUT(NOUT), .T_PUP(L_PUP), .T_PDN(L_PDN), .T_OFF(L_OFF),
    .T_ON(L_ON), .T_SETL(L_SETL), .T_MULT(L_MULT)
  ) i_clkgen_mode_ctrl (
    .clk(clk), .rst(rst), .pwr_dn_n(pwr_dn_n), .stop_n(stop_n),
    .mode_sel(mode_sel), .mult_sel(mult_sel),
    .clk_aligned(clk_aligned), .clk_pll(clk_pll), .clk_ref(clk_ref),
    .clk_p(clk_p), .clk_n(clk_n), .clk_oe(clk_oe),
    .state_oh(state_oh), .settled(settled),
    .ratio_a(ratio_a), .ratio_b(ratio_b), .mult_err(mult_err)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // R8 table, index bit i = multiplier line i
  function automatic int ref_a(logic [2:0] m);
    case (m)
      3'b000: return 4;  3'b100: return 9;  3'b010: return 6;
      3'b001: return 8;  3'b101: return 16; 3'b011: return 8;
      default: return -1;
    endcase
  endfunction

  function automatic int ref_b(logic [2:0] m);
    case (m)
      3'b000: return 1; 3'b100: return 2; 3'b010: return 1;
      3'b001: return 3; 3'b101: return 3; 3'b011: return 1;
      default: return -1;
    endcase
  endfunction

  // expected {oe,p,n} of one pair
  function automatic logic [2:0] ref_pins(int st, logic [2:0] md, logic a, logic p, logic r);
    logic lv;
    case (st)
      0: return 3'b100;
      1: return 3'b000;
      2: return {1'b1, a, ~a};
      default: begin
        if (md == 3'b001)      begin lv = p; return {1'b1, lv, ~lv}; end
        else if (md == 3'b011) begin lv = r; return {1'b1, lv, ~lv}; end
        else return 3'b000;
      end
    endcase
  endfunction

  function automatic string state_tag(int st);
    case (st)
      0: return "R2";
      1: return "R3";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check_all();
    logic [2:0] pins;
    pins = ref_pins(exp_state, exp_mode, clk_aligned, clk_pll, clk_ref);
    chk("R1", "state_oh", int'(state_oh), 1 << exp_state);
    chk(lat_tag, "settled", int'(settled), int'(exp_cnt == 0));
    chk("R8", "ratio_a", int'(ratio_a), exp_a);
    chk("R8", "ratio_b", int'(ratio_b), exp_b);
    chk("R9", "mult_err", int'(mult_err), int'(exp_err));
    for (int i = 0; i < NOUT; i++)
      chk(state_tag(exp_state), $sformatf("pair%0d {oe,p,n}", i),
          int'({clk_oe[i], clk_p[i], clk_n[i]}), int'(pins));
  endtask

  // called at a falling edge: drive, advance model, check at next falling edge
  task automatic step(logic pd, logic st, logic [2:0] md, logic [2:0] ml);
    int nst, lat;
    bit good;
    pwr_dn_n = pd; stop_n = st; mode_sel = md; mult_sel = ml;
    clk_aligned = 1'($urandom); clk_pll = 1'($urandom); clk_ref = 1'($urandom);
    if (!pd)                  nst = 0;
    else if (exp_mode != 3'b000) nst = 3;
    else if (!st)             nst = 1;
    else                      nst = 2;
    good = (ml != last_mult) && (ref_a(ml) >= 0);
    if (nst != exp_state) begin
      if (nst == 0)                         begin lat = L_PDN; lat_tag = "R11"; end
      else if (exp_state == 0)              begin lat = L_PUP; lat_tag = "R10"; end
      else if (exp_state == 2 && nst == 1)  begin lat = L_OFF; lat_tag = "R12"; end
      else if (exp_state == 1 && nst == 2)  begin lat = L_ON + L_SETL; lat_tag = "R12"; end
      else lat = 0;
      exp_cnt = lat;
    end else if (good && nst == 2) begin
      exp_cnt = L_MULT; lat_tag = "R13";
    end else if (exp_cnt > 0) begin
      exp_cnt--;
    end
    if (ml != last_mult) begin
      if (ref_a(ml) >= 0) begin exp_a = ref_a(ml); exp_b = ref_b(ml); end
      else exp_err = 1'b1;
    end
    last_mult = ml;
    if (!pd) exp_mode = md;
    exp_state = nst;
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic hold(int n, logic pd, logic st, logic [2:0] md, logic [2:0] ml);
    for (int k = 0; k < n; k++) step(pd, st, md, ml);
  endtask

  function automatic logic [2:0] pick_mode();
    if ($urandom_range(1, 0) == 0) return 3'b000;
    return 3'($urandom);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    logic pd, st;
    logic [2:0] md, ml;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R14: reset state
    chk("R14", "state_oh", int'(state_oh), 1);
    chk("R14", "settled", int'(settled), 1);
    chk("R14", "ratio_a", int'(ratio_a), 4);
    chk("R14", "ratio_b", int'(ratio_b), 1);
    chk("R14", "mult_err", int'(mult_err), 0);
    chk("R14", "clk_oe", int'(clk_oe), 3);
    rst = 1'b0;

    hold(3, 0, 1, 3'b000, 3'b100);          // R8 in power-down
    hold(15, 1, 1, 3'b000, 3'b100);         // R10 exit to normal
    hold(9, 1, 1, 3'b000, 3'b001);          // R13 hot change
    hold(3, 1, 1, 3'b011, 3'b001);          // mode change ignored
    chk("R4", "state after mode change in normal", int'(state_oh), 4);
    hold(4, 1, 0, 3'b011, 3'b001);          // R12 stop
    hold(11, 1, 1, 3'b000, 3'b001);         // R12 release
    hold(3, 1, 1, 3'b000, 3'b110);          // R9 illegal
    hold(7, 0, 1, 3'b011, 3'b110);          // R11 entry, capture ref-out
    hold(14, 1, 1, 3'b000, 3'b010);         // R6 test with ref
    hold(4, 1, 0, 3'b000, 3'b010);          // R7 stop ignored in test
    chk("R7", "state with stop low in test", int'(state_oh), 8);
    chk("R7", "pair0 enabled with stop low", int'(clk_oe[0]), 1);
    hold(6, 0, 1, 3'b001, 3'b010);
    hold(14, 1, 1, 3'b000, 3'b010);         // R6 bypass
    hold(6, 0, 1, 3'b110, 3'b010);
    hold(14, 1, 1, 3'b000, 3'b010);         // R6 output test

    pd = 1'b0; st = 1'b1; md = 3'b000; ml = 3'b010;
    for (int k = 0; k < 5000; k++) begin
      if (!pd) begin if ($urandom_range(29, 0) == 0) pd = 1'b1; end
      else if ($urandom_range(149, 0) == 0) pd = 1'b0;
      if ($urandom_range(24, 0) == 0) st = ~st;
      if ($urandom_range(9, 0) == 0) md = pick_mode();
      if ($urandom_range(39, 0) == 0) ml = 3'($urandom);
      step(pd, st, md, ml);
    end
    done = 1'b1;
    summary();
  end

endmodule